// File: doc/BRIEF.md
# Quadrature-Phase Fetch/Execute Sequencer

This block sets the instruction-cycle timing of a small processor core. It splits its input clock into four phase strobes that do not overlap. The four strobes form one instruction cycle and repeat in a fixed ring. The block runs a two-stage pipeline: in each cycle it fetches the word at the program counter while the word fetched in the previous cycle executes from the instruction register. The block owns both the program counter and the instruction register. It reads instruction words from a program memory through a synchronous read port with one clock of latency.

On the data side, the block gives the execute logic two strobes: an operand-read strobe in the second phase and a destination-write strobe in the fourth phase. Both strobes are suppressed while the instruction register holds a discarded word.

The execute logic can request a jump by raising a branch-taken request with a target address. The request is sampled in the last phase of the cycle. The program counter then loads the target, and the word already prefetched is turned into a single no-op slot. The block also drives a clock output that runs at one quarter of the input rate, aligned to the instruction cycle.

Top module: `qphase_seq`

## Requirements
- R1: `phase` is one-hot and steps bit 0 (Q1) → bit 1 (Q2) → bit 2 (Q3) → bit 3 (Q4) → bit 0 on every input clock. The first clock period after reset is released is Q1.
- R2: `clkout` is 0 during Q1 and Q2 and 1 during Q3 and Q4. This gives a period of four input clocks with a 50% duty cycle.
- R3: `pm_rd` is 1 only in Q3, and `pm_addr` presents the program counter in that phase. The memory returns the word on `pm_rdata` one clock later, in Q4.
- R4: The program counter advances by one at the Q4→Q1 boundary when no branch is accepted. It holds its value through Q1 to Q4.
- R5: At the Q4→Q1 boundary, `ir` loads the word present on `pm_rdata`. If no branch was accepted, `ir_valid` is 1 for the whole following cycle.
- R6: `opnd_rd` is 1 exactly in Q2, and `dest_wr` is 1 exactly in Q4, of every cycle where `ir_valid` is 1. Both are 0 in all other phases and cycles.
- R7: A branch is accepted when `br_take` is 1 in Q4 of a cycle with `ir_valid` = 1. On acceptance, the next cycle fetches `br_target` and carries `ir_valid` = 0 (exactly one bubble). The cycle after that executes the target word.
- R8: `br_take` has no effect outside Q4, or in a cycle where `ir_valid` is 0. The program counter still advances by one, and the next `ir_valid` is 1.
- R9: While `rst_n` is 0, the outputs are: `phase` = Q1, `pm_addr` = 0, `ir` = 0, `ir_valid` = 0, `clkout` = 0. The first cycle after reset only fetches address 0 and executes nothing.
- R10: The 13-bit program counter wraps from 0x1FFF to 0x0000 on increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_rdata | input | 14 | Program-memory read data, valid one clock after `pm_rd` |
| br_take | input | 1 | Branch-taken request from execute logic |
| br_target | input | 13 | Branch target address |
| pm_addr | output | 13 | Program-memory address (program counter) |
| pm_rd | output | 1 | Program-memory read strobe (Q3) |
| ir | output | 14 | Instruction register |
| ir_valid | output | 1 | Instruction register holds a word to execute (not a flushed slot) |
| phase | output | 4 | One-hot phase strobes, bit 0 = Q1 … bit 3 = Q4 |
| opnd_rd | output | 1 | Operand-read strobe to data memory (Q2) |
| dest_wr | output | 1 | Destination-write strobe to data memory (Q4) |
| clkout | output | 1 | Instruction-cycle clock, quarter of input rate |

## Verification
Two functions share the Q4→Q1 boundary: the normal program-counter increment with its instruction-register load, and the branch redirect with its flush. A second, quieter case is a branch request that arrives while the flushed slot is executing, which must be ignored.

The bench provokes both cases with random branch requests held over whole cycles, back-to-back branches, and pulses that end before Q4. It judges them against a cycle-level model that tracks the expected address, word and valid flag. Each phase is checked at the falling edge.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam int unsigned NUM_PHASES = 4;

  // Phase that follows p in the ring.
  function automatic phase_e phase_after(input phase_e p);
    return phase_e'(p + 2'd1);
  endfunction

  // CLKOUT level for the phase: high in the second half of the cycle.
  function automatic logic clkout_level(input phase_e p);
    return (p == PH_Q3) || (p == PH_Q4);
  endfunction

endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
  import qseq_pkg::*;
#(
  parameter int unsigned NPH = NUM_PHASES
) (
  input  logic           clk,
  input  logic           rst_n,
  output phase_e         ph,
  output logic [NPH-1:0] strobes,
  output logic           cycle_end,
  output logic           clkout
);

  phase_e ph_q;
  phase_e ph_nxt;
  logic   clk_q;

  assign ph_nxt = phase_after(ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_Q1;
      clk_q <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      clk_q <= clkout_level(ph_nxt);
    end
  end

  for (genvar i = 0; i < NPH; i++) begin : g_strobe
    assign strobes[i] = (ph_q == phase_e'(i));
  end

  assign ph        = ph_q;
  assign cycle_end = (ph_q == PH_Q4);
  assign clkout    = clk_q;

endmodule

// File: rtl/qseq_pc_unit.sv
module qseq_pc_unit #(
  parameter int unsigned PC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] cur);
    return cur + PC_W'(1);
  endfunction

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (advance) begin
      pc_q <= redirect ? target : pc_step(pc_q);
    end
  end

  assign pc = pc_q;

endmodule

// File: rtl/qseq_ir_stage.sv
module qseq_ir_stage #(
  parameter int unsigned IW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          flush,
  input  logic [IW-1:0] word,
  output logic [IW-1:0] ir,
  output logic          ir_valid
);

  logic [IW-1:0] ir_q;
  logic          vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= '0;
      vld_q <= 1'b0;
    end else if (load) begin
      ir_q  <= word;
      vld_q <= !flush;
    end
  end

  assign ir       = ir_q;
  assign ir_valid = vld_q;

endmodule

// File: rtl/qphase_seq.sv
module qphase_seq
  import qseq_pkg::*;
#(
  parameter int unsigned PC_W = 13,
  parameter int unsigned IW   = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   pm_rdata,
  input  logic            br_take,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] pm_addr,
  output logic            pm_rd,
  output logic [IW-1:0]   ir,
  output logic            ir_valid,
  output logic [3:0]      phase,
  output logic            opnd_rd,
  output logic            dest_wr,
  output logic            clkout
);

  localparam int unsigned NPH = NUM_PHASES;

  phase_e          ph;
  logic [NPH-1:0]  strobes;
  logic            cycle_end;
  logic            branch_accept;
  logic [PC_W-1:0] pc;
  logic            exec_valid;

  qseq_phase_gen #(.NPH(NPH)) i_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .strobes   (strobes),
    .cycle_end (cycle_end),
    .clkout    (clkout)
  );

  // A branch is honoured only from a real instruction, at the cycle end.
  assign branch_accept = cycle_end && br_take && exec_valid;

  qseq_pc_unit #(.PC_W(PC_W)) i_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (cycle_end),
    .redirect (branch_accept),
    .target   (br_target),
    .pc       (pc)
  );

  qseq_ir_stage #(.IW(IW)) i_ir (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cycle_end),
    .flush    (branch_accept),
    .word     (pm_rdata),
    .ir       (ir),
    .ir_valid (exec_valid)
  );

  assign pm_addr  = pc;
  assign pm_rd    = strobes[PH_Q3];
  assign opnd_rd  = strobes[PH_Q2] && exec_valid;
  assign dest_wr  = strobes[PH_Q4] && exec_valid;
  assign ir_valid = exec_valid;
  assign phase    = strobes;

endmodule

// File: rtl/qphase_seq_chk.sv
module qphase_seq_chk #(
  parameter int unsigned PC_W = 13,
  parameter int unsigned IW   = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic [IW-1:0]   pm_rdata,
  input logic            br_take,
  input logic [PC_W-1:0] br_target,
  input logic [PC_W-1:0] pm_addr,
  input logic            pm_rd,
  input logic [IW-1:0]   ir,
  input logic            ir_valid,
  input logic [3:0]      phase,
  input logic            opnd_rd,
  input logic            dest_wr,
  input logic            clkout,
  input logic            branch_accept
);

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);

  assert_phase_ring_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase == {$past(phase[2:0]), $past(phase[3])});

  assert_clkout_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkout) |-> phase[2]);

  assert_clkout_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkout) |-> phase[0]);

  assert_rd_in_q3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |-> phase[2]);

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[3] |=> $stable(pm_addr));

  assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && !branch_accept) |=> pm_addr == PC_W'($past(pm_addr) + 1'b1));

  assert_ir_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase[3] |=> ir == $past(pm_rdata));

  assert_opnd_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_rd |-> (phase[1] && ir_valid));

  assert_dest_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dest_wr |-> (phase[3] && ir_valid));

  assert_branch_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && br_take && ir_valid) |=> (pm_addr == $past(br_target)) && !ir_valid);

  assert_branch_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && !ir_valid) |=> ir_valid);

endmodule

bind qphase_seq qphase_seq_chk #(.PC_W(PC_W), .IW(IW)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pm_rdata      (pm_rdata),
  .br_take       (br_take),
  .br_target     (br_target),
  .pm_addr       (pm_addr),
  .pm_rd         (pm_rd),
  .ir            (ir),
  .ir_valid      (ir_valid),
  .phase         (phase),
  .opnd_rd       (opnd_rd),
  .dest_wr       (dest_wr),
  .clkout        (clkout),
  .branch_accept (branch_accept)
);

// File: tb/test_qphase_seq.sv
module test_qphase_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] pm_rdata = '0;
  logic        br_take = 1'b0;
  logic [12:0] br_target = '0;
  logic [12:0] pm_addr;
  logic        pm_rd;
  logic [13:0] ir;
  logic        ir_valid;
  logic [3:0]  phase;
  logic        opnd_rd;
  logic        dest_wr;
  logic        clkout;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [12:0] exp_pc = '0;
  logic [13:0] exp_ir = '0;
  logic        exp_valid = 1'b0;

  always #10 clk = ~clk;

  qphase_seq i_qphase_seq (
    .clk(clk), .rst_n(rst_n), .pm_rdata(pm_rdata), .br_take(br_take),
    .br_target(br_target), .pm_addr(pm_addr), .pm_rd(pm_rd), .ir(ir),
    .ir_valid(ir_valid), .phase(phase), .opnd_rd(opnd_rd),
    .dest_wr(dest_wr), .clkout(clkout)
  );

  // Program memory content is computed from the address.
  function automatic logic [13:0] mem_word(input logic [12:0] a);
    logic [13:0] x;
    x = {4'b0, a[9:0]} * 14'd71 + 14'd333;
    return x ^ {a[9:0], 4'hA};
  endfunction

  always @(posedge clk) begin
    if (pm_rd) pm_rdata <= mem_word(pm_addr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge inside Q1; returns at the falling edge inside the next Q1.
  task automatic run_cycle(input bit take, input logic [12:0] tgt, input bit early);
    bit accept;
    for (int p = 0; p < 4; p++) begin
      br_take   = early ? (p < 3) : take;
      br_target = tgt;
      check("R1 phase", phase, 32'(4'b0001 << p));
      check("R2 clkout", clkout, (p >= 2));
      check("R3 pm_rd", pm_rd, (p == 2));
      check("R4 pm_addr", pm_addr, exp_pc);
      check("R5 ir", ir, exp_ir);
      check("R7 ir_valid", ir_valid, exp_valid);
      check("R6 opnd_rd", opnd_rd, (p == 1) && exp_valid);
      check("R6 dest_wr", dest_wr, (p == 3) && exp_valid);
      @(negedge clk);
    end
    accept    = take && !early && exp_valid;
    exp_ir    = mem_word(exp_pc);
    exp_valid = !accept;
    exp_pc    = accept ? tgt : exp_pc + 13'd1;
    br_take   = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 phase", phase, 32'h1);
    check("R9 pm_addr", pm_addr, 0);
    check("R9 ir", ir, 0);
    check("R9 ir_valid", ir_valid, 0);
    check("R9 clkout", clkout, 0);
    rst_n = 1'b1;
    // First cycle: fetch only (exp_valid = 0)
    run_cycle(1'b1, 13'h0123, 1'b0);   // R8: request during fetch-only cycle ignored
    repeat (3) run_cycle(1'b0, '0, 1'b0);
    run_cycle(1'b1, 13'h0040, 1'b0);   // R7: branch, bubble follows
    run_cycle(1'b1, 13'h0777, 1'b0);   // R8: request in flushed slot ignored
    run_cycle(1'b0, '0, 1'b0);
    run_cycle(1'b1, 13'h0200, 1'b1);   // R8: pulse ending before Q4 ignored
    run_cycle(1'b0, '0, 1'b0);
    run_cycle(1'b1, 13'h1FFF, 1'b0);   // jump to top of space
    run_cycle(1'b0, '0, 1'b0);
    run_cycle(1'b0, '0, 1'b0);         // R10: wrap to 0
    check("R10 wrap", pm_addr, 13'h0001);
    for (int n = 0; n < 300; n++) begin
      run_cycle(($urandom % 4) == 0, 13'($urandom), ($urandom % 8) == 0);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule